// File: doc/BRIEF.md
# System Bus Clock Strobe Chain

This block turns a core clock strobe into four slower clock strobes: a system bus strobe, a peripheral strobe, a memory strobe and a static-bus strobe. Each strobe is derived from the one above it. The division ratios are not programmed at run time. They are decoded from configuration fields that board strapping or boot firmware supplies. These are a 2-bit power-control ratio select, a memory full-rate bit, a 16-bit static-bus configuration word and a legacy-mode flag.

The configuration is sampled on the first clock edge after reset is released and is held until the next reset. Each derived strobe is a one-cycle pulse. It is raised in the same cycle as the parent pulse that completes its count, so every strobe of the chain lines up with a core strobe. The decoded ratios are also driven out for readback. A reserved ratio select is flagged on an error output and handled as the largest legal ratio.

Top module: `sysbus_strobe_chain`

## Requirements
- R1: The configuration inputs are captured on the first rising clock edge after reset is released. Later changes to them alter neither the ratio outputs nor the strobe pattern until the next reset. A core strobe in that first cycle is not counted.
- R2: The bus ratio is `pwr_ratio_sel + 2`. `bus_stb` pulses together with every bus-ratio-th counted core strobe, starting from the first strobe after capture.
- R3: `periph_ratio` reads 2. `periph_stb` pulses together with every second `bus_stb`.
- R4: Outside legacy mode, `mem_ratio` is 1 when `mem_full_rate` is 1 and 2 when it is 0. In legacy mode it is always 2. `mem_stb` pulses with every mem-ratio-th `bus_stb`.
- R5: Outside legacy mode, `sbus_ratio` is `static_cfg[15:13] + 1`. `sbus_stb` pulses with every sbus-ratio-th `periph_stb`.
- R6: In legacy mode, `static_cfg[11]` = 1 gives `sbus_ratio` 5 and 0 gives 4. Bits 15:13 are ignored.
- R7: A `pwr_ratio_sel` of 3 is reserved. It raises `cfg_err` and gives a bus ratio of 4. Other values leave `cfg_err` at 0.
- R8: While reset is asserted, all strobes and `cfg_err` are 0. The ratio outputs read bus 2, peripheral 2, memory 2 and static-bus 1.
- R9: A derived strobe is never high in a cycle where `core_stb` is low. Each derived strobe lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_stb | input | 1 | Core clock strobe, one pulse per core clock period |
| pwr_ratio_sel | input | 2 | Bus ratio select (ratio = value + 2) |
| mem_full_rate | input | 1 | Memory strobe at the bus rate when set (non-legacy only) |
| static_cfg | input | 16 | Static-bus configuration word |
| legacy_mode | input | 1 | Selects the legacy static-bus ratio decode |
| bus_stb | output | 1 | System bus strobe |
| periph_stb | output | 1 | Peripheral strobe |
| mem_stb | output | 1 | Memory strobe |
| sbus_stb | output | 1 | Static-bus strobe |
| bus_ratio | output | 4 | Core pulses per bus pulse |
| periph_ratio | output | 4 | Bus pulses per peripheral pulse |
| mem_ratio | output | 4 | Bus pulses per memory pulse |
| sbus_ratio | output | 4 | Peripheral pulses per static-bus pulse |
| cfg_err | output | 1 | Reserved ratio select was captured |

## Verification
The chain is run with every ratio select, including the reserved one. It is run with both settings of the memory bit, with the divisor field at its smallest, a middle value and its largest, and in legacy mode with each value of the select bit. Each run is driven with back-to-back core strobes and again with strobes separated by idle cycles. The two cadences show whether the counters advance only on the parent strobe and not on clock cycles. Every run inverts all configuration inputs after capture, so that a design which keeps following its inputs can be told from one that holds what it sampled. Combinations that give the same ratio through different fields, such as a legacy select against a divisor field of 3 or 4, show whether the correct field is decoded in each mode.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  parameter int RW = 4;
  typedef logic [RW-1:0] ratio_t;

  typedef struct packed {
    ratio_t bus;
    ratio_t periph;
    ratio_t mem;
    ratio_t sbus;
  } ratios_t;

  parameter int NSTAGE = 4;
endpackage

// File: rtl/sbc_cfg_capture.sv
module sbc_cfg_capture #(
  parameter int SEL_W = 2,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             mem_in,
  input  logic [CFG_W-1:0] scfg_in,
  input  logic             leg_in,
  output logic [SEL_W-1:0] sel_q,
  output logic             mem_q,
  output logic [CFG_W-1:0] scfg_q,
  output logic             leg_q,
  output logic             armed_q
);
  logic cap_en;

  always_comb begin
    cap_en = ~armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      mem_q   <= 1'b0;
      scfg_q  <= '0;
      leg_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (cap_en) begin
      sel_q   <= sel_in;
      mem_q   <= mem_in;
      scfg_q  <= scfg_in;
      leg_q   <= leg_in;
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sbc_ratio_decode.sv
module sbc_ratio_decode
  import sbc_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int CFG_W   = 16,
  parameter int DIV_LSB = 13,
  parameter int DIV_W   = 3,
  parameter int LEG_BIT = 11
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             mem_full,
  input  logic [CFG_W-1:0] scfg,
  input  logic             legacy,
  output ratios_t          rat,
  output logic             err
);
  localparam logic [SEL_W-1:0] SEL_RSV = SEL_W'(3);
  localparam ratio_t           BUS_MAX = RW'(4);

  logic [DIV_W-1:0] div_fld;

  always_comb begin
    div_fld = scfg[DIV_LSB +: DIV_W];
    err     = (sel == SEL_RSV);
    rat.bus = err ? BUS_MAX : (RW'(sel) + RW'(2));
    rat.periph = RW'(2);
    if (legacy) begin
      rat.mem  = RW'(2);
      rat.sbus = scfg[LEG_BIT] ? RW'(5) : RW'(4);
    end else begin
      rat.mem  = mem_full ? RW'(1) : RW'(2);
      rat.sbus = RW'(div_fld) + RW'(1);
    end
  end
endmodule

// File: rtl/sbc_strobe_div.sv
module sbc_strobe_div #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_stb,
  input  logic [RW-1:0] ratio,
  output logic          out_stb
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] cnt_d;
  logic          cnt_en;
  logic          wrap;

  always_comb begin
    cnt_en  = en & in_stb;
    wrap    = (cnt_q == (ratio - RW'(1)));
    cnt_d   = wrap ? '0 : (cnt_q + RW'(1));
    out_stb = cnt_en & wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sysbus_strobe_chain.sv
module sysbus_strobe_chain
  import sbc_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int CFG_W   = 16,
  parameter int DIV_LSB = 13,
  parameter int DIV_W   = 3,
  parameter int LEG_BIT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_stb,
  input  logic [SEL_W-1:0] pwr_ratio_sel,
  input  logic             mem_full_rate,
  input  logic [CFG_W-1:0] static_cfg,
  input  logic             legacy_mode,
  output logic             bus_stb,
  output logic             periph_stb,
  output logic             mem_stb,
  output logic             sbus_stb,
  output logic [RW-1:0]    bus_ratio,
  output logic [RW-1:0]    periph_ratio,
  output logic [RW-1:0]    mem_ratio,
  output logic [RW-1:0]    sbus_ratio,
  output logic             cfg_err
);
  // stage order: 0 bus, 1 periph, 2 mem, 3 sbus; strobe index 0 is the core
  localparam int PARENT [NSTAGE] = '{0, 1, 1, 2};

  logic [SEL_W-1:0] sel_q;
  logic             mem_q;
  logic [CFG_W-1:0] scfg_q;
  logic             leg_q;
  logic             cfg_armed;
  ratios_t          rat;
  logic [RW-1:0]    rat_arr [NSTAGE];
  logic [NSTAGE:0]  stb;

  sbc_cfg_capture #(.SEL_W(SEL_W), .CFG_W(CFG_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_in  (pwr_ratio_sel),
    .mem_in  (mem_full_rate),
    .scfg_in (static_cfg),
    .leg_in  (legacy_mode),
    .sel_q   (sel_q),
    .mem_q   (mem_q),
    .scfg_q  (scfg_q),
    .leg_q   (leg_q),
    .armed_q (cfg_armed)
  );

  sbc_ratio_decode #(
    .SEL_W(SEL_W), .CFG_W(CFG_W), .DIV_LSB(DIV_LSB),
    .DIV_W(DIV_W), .LEG_BIT(LEG_BIT)
  ) u_dec (
    .sel      (sel_q),
    .mem_full (mem_q),
    .scfg     (scfg_q),
    .legacy   (leg_q),
    .rat      (rat),
    .err      (cfg_err)
  );

  always_comb begin
    rat_arr[0] = rat.bus;
    rat_arr[1] = rat.periph;
    rat_arr[2] = rat.mem;
    rat_arr[3] = rat.sbus;
    stb[0]     = core_stb;
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    sbc_strobe_div #(.RW(RW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_armed),
      .in_stb  (stb[PARENT[g]]),
      .ratio   (rat_arr[g]),
      .out_stb (stb[g+1])
    );
  end

  always_comb begin
    bus_stb      = stb[1];
    periph_stb   = stb[2];
    mem_stb      = stb[3];
    sbus_stb     = stb[4];
    bus_ratio    = rat.bus;
    periph_ratio = rat.periph;
    mem_ratio    = rat.mem;
    sbus_ratio   = rat.sbus;
  end
endmodule

// File: rtl/sbc_chain_chk.sv
module sbc_chain_chk #(
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_stb,
  input logic          cfg_armed,
  input logic          bus_stb,
  input logic          periph_stb,
  input logic          mem_stb,
  input logic          sbus_stb,
  input logic [RW-1:0] bus_ratio,
  input logic [RW-1:0] mem_ratio,
  input logic [RW-1:0] sbus_ratio,
  input logic          cfg_err
);
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_armed && $past(cfg_armed)) |-> ($stable(bus_ratio) && $stable(mem_ratio)
                                         && $stable(sbus_ratio) && $stable(cfg_err))); // R1
  AST_BUS_ON_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> core_stb); // R2
  AST_PERIPH_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    periph_stb |-> bus_stb); // R3
  AST_MEM_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stb |-> bus_stb); // R4
  AST_SBUS_ON_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    sbus_stb |-> periph_stb); // R5
  AST_ERR_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (bus_ratio == RW'(4))); // R7
  AST_NO_STB_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_armed |-> !(bus_stb || periph_stb || mem_stb || sbus_stb)); // R9
endmodule

bind sysbus_strobe_chain sbc_chain_chk #(.RW(sbc_pkg::RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_stb   (core_stb),
  .cfg_armed  (cfg_armed),
  .bus_stb    (bus_stb),
  .periph_stb (periph_stb),
  .mem_stb    (mem_stb),
  .sbus_stb   (sbus_stb),
  .bus_ratio  (bus_ratio),
  .mem_ratio  (mem_ratio),
  .sbus_ratio (sbus_ratio),
  .cfg_err    (cfg_err)
);

// File: tb/tb_sysbus_strobe_chain.sv
module tb_sysbus_strobe_chain;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       core_stb;
  logic [1:0] pwr_ratio_sel;
  logic       mem_full_rate;
  logic [15:0] static_cfg;
  logic       legacy_mode;
  logic       bus_stb, periph_stb, mem_stb, sbus_stb;
  logic [3:0] bus_ratio, periph_ratio, mem_ratio, sbus_ratio;
  logic       cfg_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  sysbus_strobe_chain dut (
    .clk(clk), .rst_n(rst_n), .core_stb(core_stb),
    .pwr_ratio_sel(pwr_ratio_sel), .mem_full_rate(mem_full_rate),
    .static_cfg(static_cfg), .legacy_mode(legacy_mode),
    .bus_stb(bus_stb), .periph_stb(periph_stb), .mem_stb(mem_stb),
    .sbus_stb(sbus_stb), .bus_ratio(bus_ratio), .periph_ratio(periph_ratio),
    .mem_ratio(mem_ratio), .sbus_ratio(sbus_ratio), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R8: reset values
  task automatic t_reset_state();
    rst_n = 1'b0; core_stb = 1'b0;
    pwr_ratio_sel = 2'd2; mem_full_rate = 1'b1; static_cfg = 16'hFFFF; legacy_mode = 1'b1;
    repeat (3) @(negedge clk);
    core_stb = 1'b1;
    #1;
    check("R8", "strobes in reset", {bus_stb, periph_stb, mem_stb, sbus_stb}, 0);
    check("R8", "cfg_err in reset", cfg_err, 0);
    check("R8", "bus_ratio in reset", bus_ratio, 2);
    check("R8", "periph_ratio in reset", periph_ratio, 2);
    check("R8", "mem_ratio in reset", mem_ratio, 2);
    check("R8", "sbus_ratio in reset", sbus_ratio, 1);
    core_stb = 1'b0;
  endtask

  task automatic run_case(input string tag, input logic [1:0] f, input logic mb,
                          input logic [15:0] sc, input logic lg, input int gap,
                          input int npulse);
    int rb, mr, sr, k;
    int bad_bus, bad_per, bad_mem, bad_sb, bad_idle;
    rb = (f == 2'd3) ? 4 : int'(f) + 2;
    mr = lg ? 2 : (mb ? 1 : 2);
    sr = lg ? (sc[11] ? 5 : 4) : int'(sc[15:13]) + 1;
    bad_bus = 0; bad_per = 0; bad_mem = 0; bad_sb = 0; bad_idle = 0;

    @(negedge clk);
    rst_n = 1'b0; core_stb = 1'b0;
    pwr_ratio_sel = f; mem_full_rate = mb; static_cfg = sc; legacy_mode = lg;
    @(negedge clk);
    rst_n = 1'b1;
    core_stb = 1'b1;  // R1: this pulse precedes capture and is not counted
    #1;
    if (bus_stb | periph_stb | mem_stb | sbus_stb) bad_idle++;
    @(negedge clk);
    core_stb = 1'b0;
    // R1: scramble inputs after capture
    pwr_ratio_sel = ~f; mem_full_rate = ~mb; static_cfg = ~sc; legacy_mode = ~lg;
    #1;
    check("R1", {tag, " bus_ratio held"}, bus_ratio, rb);
    check("R3", {tag, " periph_ratio"}, periph_ratio, 2);
    check("R4", {tag, " mem_ratio held"}, mem_ratio, mr);
    check(lg ? "R6" : "R5", {tag, " sbus_ratio held"}, sbus_ratio, sr);
    check("R7", {tag, " cfg_err"}, cfg_err, (f == 2'd3) ? 1 : 0);

    k = 0;
    for (int p = 0; p < npulse; p++) begin
      for (int i = 1; i < gap; i++) begin
        @(negedge clk);
        core_stb = 1'b0;
        #1;
        if (bus_stb | periph_stb | mem_stb | sbus_stb) bad_idle++;
      end
      @(negedge clk);
      core_stb = 1'b1;
      k++;
      #1;
      if (bus_stb    != ((k % rb) == 0))           bad_bus++;
      if (periph_stb != ((k % (rb*2)) == 0))       bad_per++;
      if (mem_stb    != ((k % (rb*mr)) == 0))      bad_mem++;
      if (sbus_stb   != ((k % (rb*2*sr)) == 0))    bad_sb++;
    end
    @(negedge clk);
    core_stb = 1'b0;
    check("R2", {tag, " bus_stb pattern mismatches"}, bad_bus, 0);
    check("R3", {tag, " periph_stb pattern mismatches"}, bad_per, 0);
    check("R4", {tag, " mem_stb pattern mismatches"}, bad_mem, 0);
    check(lg ? "R6" : "R5", {tag, " sbus_stb pattern mismatches"}, bad_sb, 0);
    check("R9", {tag, " strobes without core_stb"}, bad_idle, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    run_case("sel0 full D0",   2'd0, 1'b1, 16'h0000, 1'b0, 1, 40);
    run_case("sel1 half D2",   2'd1, 1'b0, 16'h4000, 1'b0, 3, 60);
    run_case("sel2 full D7",   2'd2, 1'b1, 16'hE000, 1'b0, 1, 150);
    run_case("sel2 half D3",   2'd2, 1'b0, 16'h6800, 1'b0, 2, 80);
    run_case("sel3 reserved",  2'd3, 1'b0, 16'h2000, 1'b0, 2, 50);
    run_case("legacy b11=1",   2'd0, 1'b1, 16'h0800, 1'b1, 1, 60);
    run_case("legacy b11=0",   2'd1, 1'b1, 16'hE000, 1'b1, 3, 80);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule